// File: doc/BRIEF.md
# Completion packet aligner and splitter

This block turns a read-completion job into one or more completion packets on a 512-bit AXI4-Stream source. A job gives a starting byte address, a byte count and a 32-bit word of descriptor information. The payload then arrives one byte per cycle on a separate byte stream. The block cuts the data block wherever the address crosses a multiple of the selected maximum payload size. Each piece goes out as its own packet, led by a 12-byte descriptor that carries that piece's lower address, the bytes still owed and the piece's Dword count.

The payload is padded with zero bytes so that it starts on a Dword boundary and spans whole Dwords. Two placement modes are offered. In packed mode the first payload Dword follows the descriptor directly. In quarter-aligned mode the payload sits in the second 16-byte quarter of the first beat, at an offset taken from the address. Each piece is gathered in full before it is sent, so that a packet's beats leave without gaps. The mode and the maximum payload size are sampled when a job is accepted.

Top module: `cpl_splitter`

## Requirements
- R1: The maximum payload size (MPS) is 128, 256 or 512 bytes for `mps_sel` values 0, 1 and 2, and 512 bytes for value 3. The first piece ends at the next address that is a multiple of MPS or at the end of the block, whichever comes first. Each later piece is MPS bytes long, except the final one. Exactly one packet leaves per piece, `cc_tlast` is high only on its final beat, and after the last packet `cc_tvalid` stays low.
- R2: Descriptor bytes 0 to 11 form a 96-bit little-endian word. Bits [6:0] hold the low 7 bits of the piece's start address. Bits [28:16] hold the bytes remaining in the job, this piece included. Bits [42:32] hold the piece's Dword count, ceil((addr mod 4 + length)/4). Bits [95:64] hold `job_info`. All other bits are zero.
- R3: In packed mode (`mode_aligned`=0), data byte j of a piece is at stream byte 12 + (addr mod 4) + j. Byte k of the packet is on beat k/64, lane k mod 64. Stream bytes from 12 up to the first data byte are zero.
- R4: In quarter-aligned mode (`mode_aligned`=1), data byte j of a piece is at stream byte 16 + (addr mod 16) + j. Stream bytes from 12 up to the first data byte are zero.
- R5: The packet ends at the first multiple of 4 bytes at or after the last data byte, and the bytes after the data up to that end are zero. `cc_tkeep` is all ones on every beat except the last. On the last beat its ones run contiguously from lane 0 up to the packet end.
- R6: Once a packet's first beat is offered, `cc_tvalid` stays high until the beat carrying `cc_tlast` is accepted.
- R7: While `cc_tvalid` is high and `cc_tready` is low, `cc_tdata`, `cc_tkeep` and `cc_tlast` hold their values.
- R8: `mode_aligned` and `mps_sel` are sampled when the job is accepted. Changes to them while the job is in progress have no effect on its packets.
- R9: `job_ready` is high only while no job is in progress. `in_ready` is high only while the current piece is being gathered. Exactly `job_count` payload bytes are taken per job, and `job_count` must be between 1 and 4096.
- R10: After reset, `job_ready` is high and `in_ready` and `cc_tvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_aligned | input | 1 | 1 selects quarter-aligned placement, 0 selects packed placement |
| mps_sel | input | 2 | Maximum payload size select |
| job_valid | input | 1 | Job request valid |
| job_ready | output | 1 | Job accepted when high with job_valid |
| job_addr | input | 16 | Starting byte address of the data block |
| job_count | input | 13 | Byte count of the data block |
| job_info | input | 32 | Descriptor information copied into every packet |
| in_valid | input | 1 | Payload byte valid |
| in_ready | output | 1 | Payload byte accepted when high with in_valid |
| in_byte | input | 8 | Payload byte |
| cc_tdata | output | 512 | Stream data |
| cc_tkeep | output | 64 | Stream byte enables |
| cc_tvalid | output | 1 | Stream valid |
| cc_tlast | output | 1 | Last beat of a packet |
| cc_tready | input | 1 | Stream ready from the sink |

## Verification
The hardest case to reach is a piece that fills all nine beats of the gather buffer. That takes quarter-aligned mode, an address with offset 15 inside its 16-byte quarter, a 512-byte payload size and a block long enough to cross that boundary. The bench builds exactly this job and holds `cc_tready` low on a regular pattern while it runs. The held beats, the descriptor of the second piece and the short tail piece are then all checked. Other jobs change the mode and size inputs just after acceptance, to show that the sampled values govern the whole job.

// File: rtl/cpl_splitter.sv
module cpl_splitter #(
  parameter int BYTES   = 64,
  parameter int ADDR_W  = 16,
  parameter int CNT_W   = 13,
  parameter int MAX_MPS = 512
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_aligned,
  input  logic [1:0]         mps_sel,
  input  logic               job_valid,
  output logic               job_ready,
  input  logic [ADDR_W-1:0]  job_addr,
  input  logic [CNT_W-1:0]   job_count,
  input  logic [31:0]        job_info,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [7:0]         in_byte,
  output logic [BYTES*8-1:0] cc_tdata,
  output logic [BYTES-1:0]   cc_tkeep,
  output logic               cc_tvalid,
  output logic               cc_tlast,
  input  logic               cc_tready
);
  localparam int LANE_W = $clog2(BYTES);
  localparam int DEPTH  = (32 + MAX_MPS + BYTES - 1) / BYTES;
  localparam int POS_W  = $clog2(DEPTH * BYTES);
  localparam int IDX_W  = POS_W - LANE_W;

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_FILL, S_SEND} st_t;

  st_t               state;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  rem, left;
  logic [31:0]       info_q;
  logic              mode_q;
  logic [1:0]        sel_q;
  logic [POS_W-1:0]  pos;
  logic [IDX_W-1:0]  beat, last_idx_q;
  logic [LANE_W:0]   last_n_q;
  logic [BYTES*8-1:0] mem [DEPTH];

  logic [CNT_W-1:0]  mps, room, plen;
  logic [POS_W-1:0]  start_p, end_p;
  logic [IDX_W-1:0]  last_idx;
  logic [LANE_W:0]   last_n;
  logic [10:0]       dwc;
  logic [95:0]       desc;

  assign mps      = CNT_W'(128) << ((sel_q == 2'd3) ? 2'd2 : sel_q);
  assign room     = mps - (CNT_W'(addr) & (mps - CNT_W'(1)));
  assign plen     = (rem < room) ? rem : room;
  assign start_p  = mode_q ? POS_W'(16) + POS_W'(addr[3:0]) : POS_W'(12) + POS_W'(addr[1:0]);
  assign end_p    = (start_p + POS_W'(plen) + POS_W'(3)) & ~POS_W'(3);
  assign last_idx = IDX_W'((end_p - POS_W'(1)) >> LANE_W);
  assign last_n   = (LANE_W+1)'(end_p - {last_idx, LANE_W'(0)});
  assign dwc      = 11'((CNT_W'(addr[1:0]) + plen + CNT_W'(3)) >> 2);
  assign desc     = {info_q, 21'b0, dwc, 3'b0, rem, 9'b0, addr[6:0]};

  assign job_ready = (state == S_IDLE);
  assign in_ready  = (state == S_FILL);
  assign cc_tvalid = (state == S_SEND);
  assign cc_tlast  = cc_tvalid && (beat == last_idx_q);
  assign cc_tdata  = cc_tvalid ? mem[beat] : '0;
  assign cc_tkeep  = !cc_tvalid ? '0 :
                     cc_tlast ? ({BYTES{1'b1}} >> (BYTES - int'(last_n_q))) : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      addr       <= '0;
      rem        <= '0;
      left       <= '0;
      info_q     <= '0;
      mode_q     <= 1'b0;
      sel_q      <= '0;
      pos        <= '0;
      beat       <= '0;
      last_idx_q <= '0;
      last_n_q   <= '0;
    end else begin
      case (state)
        S_IDLE: if (job_valid) begin
          addr   <= job_addr;
          rem    <= job_count;
          info_q <= job_info;
          mode_q <= mode_aligned;
          sel_q  <= mps_sel;
          state  <= S_HDR;
        end
        S_HDR: begin
          pos        <= start_p;
          left       <= plen;
          last_idx_q <= last_idx;
          last_n_q   <= last_n;
          addr       <= addr + ADDR_W'(plen);
          rem        <= rem - plen;
          state      <= S_FILL;
        end
        S_FILL: if (in_valid) begin
          pos  <= pos + POS_W'(1);
          left <= left - CNT_W'(1);
          if (left == CNT_W'(1)) begin
            beat  <= '0;
            state <= S_SEND;
          end
        end
        S_SEND: if (cc_tready) begin
          if (cc_tlast) state <= (rem == '0) ? S_IDLE : S_HDR;
          else          beat  <= beat + IDX_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_HDR) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      mem[0][95:0] <= desc;
    end else if (state == S_FILL && in_valid) begin
      mem[pos[POS_W-1:LANE_W]][{pos[LANE_W-1:0], 3'b000} +: 8] <= in_byte;
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cc_tvalid && !cc_tready |=> cc_tvalid && $stable(cc_tdata) && $stable(cc_tkeep) && $stable(cc_tlast));

  assert_no_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cc_tvalid && cc_tready && !cc_tlast |=> cc_tvalid);

  assert_fill_to_send_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (left == CNT_W'(1)) |=> cc_tvalid && !in_ready);

  assert_keep_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cc_tvalid |-> (((cc_tkeep + BYTES'(1)) & cc_tkeep) == '0) &&
                  ($countones(cc_tkeep) % 4 == 0) && (cc_tlast || (&cc_tkeep)));

  assert_one_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({job_ready, in_ready, cc_tvalid}));
endmodule

// File: tb/sim_cpl_splitter.sv
`timescale 1ns/1ps
module sim_cpl_splitter;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode_aligned = 1'b0;
  logic [1:0]   mps_sel = '0;
  logic         job_valid = 1'b0;
  logic         job_ready;
  logic [15:0]  job_addr = '0;
  logic [12:0]  job_count = '0;
  logic [31:0]  job_info = '0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [7:0]   in_byte = '0;
  logic [511:0] cc_tdata;
  logic [63:0]  cc_tkeep;
  logic         cc_tvalid;
  logic         cc_tlast;
  logic         cc_tready = 1'b1;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  cpl_splitter u0 (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    @(negedge clk); #1;
    check(job_ready && !in_ready && !cc_tvalid, req, "idle ports {job_ready,in_ready,tvalid}",
          {job_ready, in_ready, cc_tvalid}, 3'b100);
  endtask

  task automatic feed(input int n, input logic [7:0] seed, input int gap);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      if (gap != 0 && (j % gap) == 1) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_byte  = seed + 8'(j);
      #1;
      while (!in_ready) begin
        @(negedge clk); #1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic collect(input logic [15:0] a, input int n, input logic [31:0] inf,
                         input bit md, input logic [1:0] sel, input int stall);
    int ca = a;
    int cr = n;
    int jidx = 0;
    while (cr > 0) begin
      int mps = 128 << ((sel == 2'd3) ? 2 : int'(sel));
      int room = mps - (ca % mps);
      int len = (cr < room) ? cr : room;
      int start = md ? 16 + (ca % 16) : 12 + (ca % 4);
      int endp = ((start + len + 3) / 4) * 4;
      int nb = (endp + 63) / 64;
      int dw = ((ca % 4) + len + 3) / 4;
      logic [95:0] desc = {inf, 21'b0, 11'(dw), 3'b0, 13'(cr), 9'b0, 7'(ca)};
      for (int bt = 0; bt < nb; bt++) begin
        bit held = 1'b0;
        logic [511:0] hd;
        logic [63:0] hk;
        logic hl;
        int bad_d = -1, bad_p = -1, bad_z = -1;
        logic [63:0] ek;
        forever begin
          @(negedge clk);
          cc_tready = (stall == 0) || ((cyc % stall) != 0);
          #1;
          if (held) begin
            check(cc_tvalid && cc_tdata == hd && cc_tkeep == hk && cc_tlast == hl,
                  "R7", "beat held under back-pressure", cc_tkeep, hk);
            held = 1'b0;
          end
          if (cc_tvalid && cc_tready) break;
          if (cc_tvalid) begin
            held = 1'b1; hd = cc_tdata; hk = cc_tkeep; hl = cc_tlast;
          end
        end
        for (int l = 0; l < 64; l++) begin
          int p = bt * 64 + l;
          logic [7:0] got = cc_tdata[8*l +: 8];
          if (p < 12) begin
            if (got !== desc[8*p +: 8] && bad_d < 0) bad_d = l;
          end else if (p >= start && p < start + len) begin
            if (got !== 8'(inf[7:0] + 8'(jidx + p - start)) && bad_p < 0) bad_p = l;
          end else begin
            if (got !== 8'h00 && bad_z < 0) bad_z = l;
          end
          ek[l] = (bt < nb - 1) || (p < endp);
        end
        if (bt == 0) check(bad_d < 0, "R2", "descriptor bytes, first bad lane", bad_d, -1);
        check(bad_p < 0, md ? "R4" : "R3", "payload placement, first bad lane", bad_p, -1);
        check(bad_z < 0, "R5", "null padding, first bad lane", bad_z, -1);
        check(cc_tkeep == ek, "R5", "tkeep", cc_tkeep, ek);
        check(cc_tlast == (bt == nb - 1), "R1", "tlast on beat", cc_tlast, bt == nb - 1);
      end
      jidx += len; ca += len; cr -= len;
    end
    @(negedge clk);
    cc_tready = 1'b1;
    #1;
    check(!cc_tvalid && job_ready && !in_ready, "R1", "no packet after last piece (R9 ports)",
          {cc_tvalid, job_ready, in_ready}, 3'b010);
  endtask

  task automatic run_job(input logic [15:0] a, input int n, input logic [31:0] inf,
                         input bit md, input logic [1:0] sel, input int stall,
                         input int gap, input bit flip);
    @(negedge clk);
    mode_aligned = md; mps_sel = sel;
    job_addr = a; job_count = 13'(n); job_info = inf; job_valid = 1'b1;
    #1;
    while (!job_ready) begin
      @(negedge clk); #1;
    end
    @(negedge clk);
    job_valid = 1'b0;
    if (flip) begin
      mode_aligned = ~md;
      mps_sel = (sel == 2'd0) ? 2'd2 : 2'd0;
    end
    #1;
    check(!job_ready, "R9", "job_ready low while job in progress", job_ready, 0);
    fork
      feed(n, inf[7:0], gap);
      collect(a, n, inf, md, sel, stall);
    join
  endtask

  task automatic t_reset;
    check_idle("R10");
  endtask

  task automatic t_small_packed;
    run_job(16'd7, 3, 32'hA5A5_0011, 1'b0, 2'd0, 0, 0, 1'b0);
    run_job(16'd0, 64, 32'h1234_5620, 1'b0, 2'd1, 3, 0, 1'b0);
  endtask

  task automatic t_quarter;
    run_job(16'h0025, 40, 32'hC0DE_0040, 1'b1, 2'd0, 0, 0, 1'b0);
    run_job(16'h00FE, 70, 32'h0BAD_F00D, 1'b1, 2'd0, 4, 3, 1'b0);
  endtask

  task automatic t_split;
    run_job(16'd500, 300, 32'h5111_7700, 1'b0, 2'd0, 0, 0, 1'b0);
    run_job(16'd3, 1100, 32'h7777_0003, 1'b1, 2'd1, 3, 0, 1'b0);
    run_job(16'd255, 600, 32'h3333_0099, 1'b0, 2'd3, 0, 0, 1'b0);
  endtask

  task automatic t_max_beats;
    run_job(16'h020F, 700, 32'h9999_00F1, 1'b1, 2'd2, 2, 0, 1'b0);
  endtask

  task automatic t_sampled_cfg;
    run_job(16'h0041, 400, 32'h8888_0042, 1'b1, 2'd0, 0, 0, 1'b1);
    run_job(16'h0102, 300, 32'h4444_0017, 1'b0, 2'd2, 5, 0, 1'b1);
    check_idle("R8");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_small_packed();
    t_quarter();
    t_split();
    t_max_beats();
    t_sampled_cfg();
    check_idle("R9");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule